// File: doc/BRIEF.md
# Display Backlight PWM Generator

This block drives a display backlight with a single pulse-width modulated output. A period always spans 256 prescaled ticks. An 8-bit compare value sets how many of those ticks are active, so the duty cycle can go from 0/256 up to 255/256 and can never reach the whole period. A 3-bit field divides the counting source by a power of two. A polarity bit chooses whether the active portion is driven high or low. The counting source is either every system clock cycle or a slow tick pulse. The slow tick is supplied by the surrounding logic, in the system clock domain, as a one-cycle strobe.

Software controls the block through a small register port. The port has a write strobe with a per-bit write mask, so a partial update leaves the other fields untouched, and a combinational read path. Starting and stopping are requests, not a plain enable flop. The block has separate write-one command locations for start and stop, and a status bit that follows each request with a lag. Software polls the status bit until it shows the state it asked for. A stop request always lets the current period finish. New compare and prescaler values are copied into the counting logic only at the start of a period, so the output never carries a shortened or stretched pulse.

Top module: `bl_pwm`

## Requirements
- R1: After reset every readable field reads 0, the status bit (address 4, bit 0) reads 0 and the output is high, which is the idle level for polarity 0.
- R2: Address 0 bit 0 selects the counting source. Address 1 holds the compare value in bits 15:8, the polarity in bit 4 and the prescaler select in bits 2:0. A write changes only the bits whose write-mask bit is 1, and each field reads back as it was written.
- R3: A write that would leave the prescaler select at 7 leaves that field unchanged; the other fields in the same write still update.
- R4: With compare value C and prescaler select P, each period lasts 256·2^P counting-source ticks, and the output is at its active level for exactly C·2^P of them, so C = 255 still leaves one inactive tick per period.
- R5: With polarity 1 the active level is high; with polarity 0 the active level is low.
- R6: With the source-select bit at 1 the block counts every clock cycle; at 0 it counts only cycles where the slow tick input is high.
- R7: Writing 1 to bit 0 of address 2 requests a start and writing 1 to bit 0 of address 3 requests a stop; writing 0 to either has no effect on the running state.
- R8: After a start request from the stopped state, the status bit rises on the second counting-source tick after the command is taken.
- R9: After a stop request while running, the status bit stays 1 and the output keeps modulating until the current period ends; then the status bit falls.
- R10: A compare or prescaler change written while running takes effect only at the next period boundary.
- R11: Whenever the status bit is 0, the output holds the inactive level for the current polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle strobe of the slow counting source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| wr_mask | input | 32 | Per-bit write enable for configuration writes |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| pwm_o | output | 1 | Backlight PWM output |

## Verification
The assertions assume that slow_tick is a clean strobe in the clock domain and that the register port carries at most one write per cycle. They also assume that command writes never coincide with a configuration write. The bench drives every input at the falling edge, one register access at a time, and generates the slow tick as a regular pulse every fourth cycle. Duty is measured over windows of exactly one period, so the count does not depend on the phase at which the window starts.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 8;
  localparam int PS_W    = 3;
  localparam int PS_MAX  = 6;

  localparam logic [ADDR_W-1:0] A_GEN  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd1;
  localparam logic [ADDR_W-1:0] A_ON   = 3'd2;
  localparam logic [ADDR_W-1:0] A_OFF  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

  localparam int CV_LSB  = 8;
  localparam int POL_BIT = 4;
  localparam int PS_LSB  = 0;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_START = 2'd1,
    ST_RUN   = 2'd2,
    ST_STOP  = 2'd3
  } run_state_e;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] wr_mask,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              status,
  output logic [DATA_W-1:0] rd_data,
  output logic              clk_sel,
  output logic [CNT_W-1:0]  cfg_cval,
  output logic              cfg_pol,
  output logic [PS_W-1:0]   cfg_ps,
  output logic              on_cmd,
  output logic              off_cmd
);
  logic [CNT_W-1:0] cv_m, cv_d, cv_new;
  logic [PS_W-1:0]  ps_m, ps_d, ps_new;
  logic             cfg_wr, gen_wr;

  assign cfg_wr = wr_en && (wr_addr == A_CFG);
  assign gen_wr = wr_en && (wr_addr == A_GEN);
  assign cv_m   = wr_mask[CV_LSB +: CNT_W];
  assign cv_d   = wr_data[CV_LSB +: CNT_W];
  assign ps_m   = wr_mask[PS_LSB +: PS_W];
  assign ps_d   = wr_data[PS_LSB +: PS_W];
  assign cv_new = (cfg_cval & ~cv_m) | (cv_d & cv_m);
  assign ps_new = (cfg_ps & ~ps_m) | (ps_d & ps_m);

  // command strobes: a 0 in bit 0 is a no-op
  assign on_cmd  = wr_en && (wr_addr == A_ON)  && wr_data[0];
  assign off_cmd = wr_en && (wr_addr == A_OFF) && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_sel  <= 1'b0;
      cfg_cval <= '0;
      cfg_pol  <= 1'b0;
      cfg_ps   <= '0;
    end else begin
      if (gen_wr && wr_mask[0]) clk_sel <= wr_data[0];
      if (cfg_wr) begin
        cfg_cval <= cv_new;
        if (wr_mask[POL_BIT]) cfg_pol <= wr_data[POL_BIT];
        if (int'(ps_new) <= PS_MAX) cfg_ps <= ps_new;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_GEN:  rd_data[0] = clk_sel;
      A_CFG: begin
        rd_data[CV_LSB +: CNT_W] = cfg_cval;
        rd_data[POL_BIT]         = cfg_pol;
        rd_data[PS_LSB +: PS_W]  = cfg_ps;
      end
      A_STAT: rd_data[0] = status;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/bl_pwm_prescaler.sv
module bl_pwm_prescaler
  import bl_pwm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            src_tick,
  input  logic [PS_W-1:0] ps_act,
  output logic            ptick
);
  logic [PS_MAX-1:0] div_cnt;
  logic [PS_MAX-1:0] lo_mask;

  assign lo_mask = ~({PS_MAX{1'b1}} << ps_act);
  assign ptick   = run && src_tick && ((div_cnt & lo_mask) == lo_mask);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) div_cnt <= '0;
    else if (src_tick)  div_cnt <= div_cnt + 1'b1;
  end
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
  import bl_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             on_cmd,
  input  logic             off_cmd,
  input  logic             src_tick,
  input  logic             ptick,
  input  logic [CNT_W-1:0] cfg_cval,
  input  logic [PS_W-1:0]  cfg_ps,
  input  logic             cfg_pol,
  output logic             run,
  output logic [PS_W-1:0]  ps_act,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cval_act,
  output run_state_e       state,
  output logic             status,
  output logic             pwm_out
);
  localparam int START_TICKS = 2;

  logic st_cnt;
  logic fire;
  logic wrap;
  logic active;

  assign run    = (state == ST_RUN) || (state == ST_STOP);
  assign status = run;
  assign fire   = (state == ST_START) && src_tick && (int'(st_cnt) == START_TICKS - 1) && !off_cmd;
  assign wrap   = run && ptick && (cnt == {CNT_W{1'b1}});
  assign active = run && (cnt < cval_act);
  assign pwm_out = cfg_pol ? active : !active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_OFF;
      st_cnt <= 1'b0;
    end else begin
      case (state)
        ST_OFF: if (on_cmd) begin
          state  <= ST_START;
          st_cnt <= 1'b0;
        end
        ST_START: begin
          if (off_cmd)       state <= ST_OFF;
          else if (fire)     state <= ST_RUN;
          else if (src_tick) st_cnt <= 1'b1;
        end
        ST_RUN:  if (off_cmd) state <= ST_STOP;
        ST_STOP: begin
          if (on_cmd)    state <= ST_RUN;
          else if (wrap) state <= ST_OFF;
        end
        default: state <= ST_OFF;
      endcase
    end
  end

  // counter and period-boundary shadow load
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      cval_act <= '0;
      ps_act   <= '0;
    end else begin
      if (!run)       cnt <= '0;
      else if (ptick) cnt <= cnt + 1'b1;
      if (fire || wrap) begin
        cval_act <= cfg_cval;
        ps_act   <= cfg_ps;
      end
    end
  end
endmodule

// File: rtl/bl_pwm.sv
module bl_pwm
  import bl_pwm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_tick,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [31:0] wr_mask,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        pwm_o
);
  logic             clk_sel, cfg_pol, on_cmd, off_cmd;
  logic [CNT_W-1:0] cfg_cval, cnt, cval_act;
  logic [PS_W-1:0]  cfg_ps, ps_act;
  logic             src_tick, ptick, run, status;
  run_state_e       state;

  assign src_tick = clk_sel ? 1'b1 : slow_tick;

  bl_pwm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_mask(wr_mask), .rd_addr(rd_addr),
    .status(status), .rd_data(rd_data), .clk_sel(clk_sel),
    .cfg_cval(cfg_cval), .cfg_pol(cfg_pol), .cfg_ps(cfg_ps),
    .on_cmd(on_cmd), .off_cmd(off_cmd)
  );

  bl_pwm_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .src_tick(src_tick),
    .ps_act(ps_act), .ptick(ptick)
  );

  bl_pwm_core u_core (
    .clk(clk), .rst_n(rst_n), .on_cmd(on_cmd), .off_cmd(off_cmd),
    .src_tick(src_tick), .ptick(ptick), .cfg_cval(cfg_cval),
    .cfg_ps(cfg_ps), .cfg_pol(cfg_pol), .run(run), .ps_act(ps_act),
    .cnt(cnt), .cval_act(cval_act), .state(state), .status(status),
    .pwm_out(pwm_o)
  );
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk
  import bl_pwm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [31:0]      wr_data,
  input logic [31:0]      wr_mask,
  input logic             pwm_o,
  input logic             status,
  input logic             cfg_pol,
  input logic [PS_W-1:0]  cfg_ps,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cval_act,
  input run_state_e       state
);
  p_idle_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !status |-> (pwm_o == !cfg_pol));

  p_start_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_ON && wr_data[0] && state == ST_OFF)
      |=> (!status && state == ST_START));

  p_ps_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CFG && (wr_mask[2:0] == 3'b111) && (wr_data[2:0] == 3'd7))
      |=> $stable(cfg_ps));

  p_stop_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_OFF && wr_data[0] && state == ST_RUN) |=> status);

  p_never_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status && cnt == {CNT_W{1'b1}}) |-> (pwm_o == !cfg_pol));

  p_zero_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_ON && !wr_data[0] && state == ST_OFF) |=> (state == ST_OFF));

  p_shadow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cval_act) |-> (cnt == '0));
endmodule

bind bl_pwm bl_pwm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .wr_mask(wr_mask), .pwm_o(pwm_o), .status(status),
  .cfg_pol(cfg_pol), .cfg_ps(cfg_ps), .cnt(cnt), .cval_act(cval_act),
  .state(state)
);

// File: tb/bl_pwm_tb.sv
module bl_pwm_tb;
  localparam int NV = 8;
  // vector fields: {sel, pol, ps[2:0], cval[7:0]}
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 1'b1, 3'd0, 8'd0},
    {1'b1, 1'b1, 3'd0, 8'd255},
    {1'b1, 1'b0, 3'd0, 8'd128},
    {1'b1, 1'b1, 3'd2, 8'd1},
    {1'b0, 1'b0, 3'd1, 8'd77},
    {1'b1, 1'b1, 3'd3, 8'd200},
    {1'b1, 1'b1, 3'd6, 8'd10},
    {1'b0, 1'b1, 3'd0, 8'd33}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] wr_mask = '0;
  logic [2:0]  rd_addr = 3'd4;
  logic [31:0] rd_data;
  logic        pwm_o;
  int checks = 0;
  int errors = 0;
  int div4 = 0;

  bl_pwm u_dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwm_o(pwm_o)
  );

  always #4 clk = ~clk;

  initial forever begin
    @(negedge clk);
    div4 = (div4 + 1) % 4;
    slow_tick = (div4 == 3);
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired");
    errors++;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [31:0] m);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_mask = m;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; wr_mask = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
    rd_addr = 3'd4;
    #1;
  endtask

  task automatic wait_stat(input logic val, input int lim, output int n);
    n = 0;
    while (rd_data[0] !== val && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic count_active(input logic pol, input int win, output int c);
    c = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (pwm_o == pol) c++;
    end
  endtask

  initial begin
    logic [31:0] d;
    int n, c, scale;
    logic sel, pol;
    logic [2:0] ps;
    logic [7:0] cv;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, d); check("R1 gen reg", d, 0);
    rd(3'd1, d); check("R1 cfg reg", d, 0);
    check("R1 status", rd_data[0], 0);
    check("R1 idle output", pwm_o, 1);

    // R2 field positions and masked update
    wr(3'd1, 32'h0000_A515, 32'hFFFF_FFFF);
    rd(3'd1, d); check("R2 cfg readback", d, 32'h0000_A515);
    wr(3'd1, 32'h0000_0000, 32'h0000_0010);
    rd(3'd1, d); check("R2 masked pol write", d, 32'h0000_A505);
    wr(3'd1, 32'h0000_3C00, 32'h0000_FF00);
    rd(3'd1, d); check("R2 masked cval write", d, 32'h0000_3C05);
    wr(3'd0, 32'h1, 32'h1);
    rd(3'd0, d); check("R2 gen readback", d, 1);
    // R11 idle level follows polarity 0 -> output high
    check("R11 idle output pol0", pwm_o, 1);

    // R3 ps=7 ignored, cval still written
    wr(3'd1, 32'h0000_4407, 32'h0000_FF07);
    rd(3'd1, d); check("R3 ps 7 ignored", d, 32'h0000_4405);

    // R7 zero writes ignored
    wr(3'd2, 32'h0, 32'hFFFF_FFFF);
    repeat (10) @(negedge clk);
    check("R7 zero enable ignored", rd_data[0], 0);

    // R8 exact status lag with clock source selected
    wr(3'd1, 32'h0000_8010, 32'h0000_FF17);
    wr(3'd2, 32'h1, 32'h1);
    check("R8 status after cmd edge", rd_data[0], 0);
    @(negedge clk);
    check("R8 status after one tick", rd_data[0], 0);
    @(negedge clk);
    check("R8 status after two ticks", rd_data[0], 1);

    // R9 stop waits for period end
    repeat (5) @(negedge clk);
    wr(3'd3, 32'h0, 32'hFFFF_FFFF);
    check("R7 zero disable ignored", rd_data[0], 1);
    wr(3'd3, 32'h1, 32'h1);
    check("R9 status held after stop", rd_data[0], 1);
    wait_stat(1'b0, 400, n);
    check("R9 stop waited for period end", (n > 200 && n < 256) ? 1 : 0, 1);
    check("R11 output idle after stop", pwm_o, 0);

    // R10 compare change applies at next period
    wr(3'd1, 32'h0000_0010, 32'h0000_FF17);
    wr(3'd2, 32'h1, 32'h1);
    wait_stat(1'b1, 20, n);
    repeat (10) @(negedge clk);
    wr(3'd1, 32'h0000_C800, 32'h0000_FF00);
    count_active(1'b1, 200, c);
    check("R10 no active pulse before boundary", c, 0);
    repeat (100) @(negedge clk);
    count_active(1'b1, 256, c);
    check("R10 new compare after boundary", c, 200);
    wr(3'd3, 32'h1, 32'h1);
    wait_stat(1'b0, 400, n);

    // table walk: R4 duty, R5 polarity, R6 source select
    for (int v = 0; v < NV; v++) begin
      {sel, pol, ps, cv} = VEC[v];
      scale = sel ? 1 : 4;
      wr(3'd0, {31'd0, sel}, 32'h1);
      wr(3'd1, {16'd0, cv, 3'd0, pol, 1'b0, ps}, 32'h0000_FF17);
      wr(3'd2, 32'h1, 32'h1);
      wait_stat(1'b1, 64, n);
      check("R6 started", rd_data[0], 1);
      count_active(pol, (256 << ps) * scale, c);
      check(pol ? "R4 R5 duty pol1" : "R4 R5 duty pol0", c, (int'(cv) << ps) * scale);
      wr(3'd3, 32'h1, 32'h1);
      wait_stat(1'b0, 70000, n);
      check("R11 stopped idle level", pwm_o, !pol);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule